// File: doc/BRIEF.md
# Nested Two-Level PWM Generator

This block produces the on/off gate of up to 36 LED channels from two nested pulse-width layers. A slow 8-bit outer layer walks through 256 steps, and each outer step contains one complete period of a fast inner layer. The inner layer is 10 bits wide (1024 counts) or 8 bits wide (256 counts). A channel is lit during an outer step only if that step lies below the channel's outer duty. Within such a step, it is lit while the inner count lies below the channel's inner duty. The effective duty is therefore the product of the two fractions.

A single clock-enable tick paces everything. It stands for the fastest internal oscillator rate. In 10-bit mode the inner counter advances on every tick. In 8-bit mode a prescaler slows it by 4, 2 or 1, which gives the three selectable inner and outer rate pairs.

Channels fall into three colour classes (channel index modulo 3). Each class has a 2-bit mode:
- full nesting,
- inner layer only,
- always on (DC),
- always off.

A software shutdown input forces every output low but keeps the stored duties. Duty inputs are captured into shadow registers only on an update strobe. In RGB mode, every triplet of channels shares the inner duty of its triplet index. Each channel of the triplet keeps its own outer duty. The inner and outer counters and two period-start pulses are exported for a separate phase-shift block.

Top module: `pwm_nest_gen`

## Requirements
- R1: While `rst_n` is low, `ch_on_o`, `inner_cnt_o`, `outer_cnt_o`, `inner_start_o` and `outer_start_o` are all zero after the next clock edge.
- R2: With `wide_i`=1 the inner counter advances on every tick and wraps after 1023, so the inner period is 1024 ticks whatever `fsel_i` holds. With `wide_i`=0 it wraps after 255 and advances every 4 ticks (`fsel_i`=00), every 2 ticks (01) or every tick (10, 11). `inner_start_o` pulses for one cycle as the counter returns to 0.
- R3: The outer counter moves only on an inner wrap. It increments by one there and wraps from 255 to 0. `outer_start_o` pulses, together with `inner_start_o`, when both counters return to 0.
- R4: While `tick_i` is low, both counters hold their values.
- R5: In class mode 00, a channel is on exactly when the inner count is below its inner duty and the outer count is below its outer duty. A zero duty keeps it off for the whole period.
- R6: In class mode 01, the outer duty has no effect and the channel follows the inner comparison alone.
- R7: Channel c takes its mode from `mode_i[2*(c mod 3) +: 2]`. Mode 10 keeps the channel on and mode 11 keeps it off.
- R8: With `wide_i`=0, only bits [7:0] of a channel's 10-bit inner duty are compared; bits [9:8] are ignored.
- R9: While `sw_shdn_i` is high, all outputs are off. After release, outputs follow the duties stored before shutdown.
- R10: Shadow duties load from `hfp_duty_i`/`lfp_duty_i` only in a cycle with `update_i` high. Input changes without the strobe do not affect the outputs.
- R11: With `rgb_i`=1, channel c uses inner duty field c/3 (integer division) of the shadow, while keeping its own outer duty field c. Field c of the inner duty sits at bits [10c+9:10c], and field c of the outer duty at [8c+7:8c].
- R12: `ch_on_o` is registered: its value after a clock edge is computed from the counter values, modes and shadow duties present before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Clock enable at the fastest oscillator rate |
| wide_i | input | 1 | 1 selects 10-bit inner resolution, 0 selects 8-bit |
| fsel_i | input | 2 | Inner rate select in 8-bit mode |
| mode_i | input | 6 | Per-colour-class mode, 2 bits per class |
| sw_shdn_i | input | 1 | Software shutdown, forces all outputs off |
| rgb_i | input | 1 | Triplets share one inner duty field |
| update_i | input | 1 | Strobe that loads the shadow duties |
| hfp_duty_i | input | 360 | Inner duties, 10 bits per channel |
| lfp_duty_i | input | 288 | Outer duties, 8 bits per channel |
| ch_on_o | output | 36 | Gate per channel |
| inner_cnt_o | output | 10 | Current inner counter |
| outer_cnt_o | output | 8 | Current outer counter |
| inner_start_o | output | 1 | Pulse at start of each inner period |
| outer_start_o | output | 1 | Pulse at start of each outer period |

## Verification
The gate vector is predicted every cycle from the exported counters. The bench runs seeded random duties, modes, resolutions and rate selects under a sparse tick, together with runs where the outer duty is kept small so that the outer threshold is crossed as the outer counter moves. The directed runs separate the following faults:
- Zero duties and inner-only mode catch a compare that is off by one or an outer term left in place.
- An inner duty with only bits 9:8 set exposes 8-bit mode reading the wrong width.
- Changing inputs without the strobe, and RGB mode with distinct per-channel duties, reveal shadow and mapping faults.
- Measured inner periods for each rate select, and a full outer sweep, separate prescaler faults from wrap faults.

// File: rtl/pwm_nest_pkg.sv
// Shared types and helpers for the nested PWM generator.
// Assumes three colour classes and a 2-bit divide selector.
package pwm_nest_pkg;

    // Per-class output mode.
    typedef enum logic [1:0] {
        GM_NESTED = 2'b00,
        GM_INNER  = 2'b01,
        GM_DC     = 2'b10,
        GM_OFF    = 2'b11
    } gmode_e;

    localparam int CLASS_CNT = 3;
    localparam int GMODE_W   = 2;

    // Last prescaler count before an inner step, from the resolution and rate select.
    function automatic logic [1:0] prescale_last(input logic wide, input logic [1:0] fsel);
        if (wide)
            return 2'd0;
        else if (fsel == 2'b00)
            return 2'd3;
        else if (fsel == 2'b01)
            return 2'd1;
        else
            return 2'd0;
    endfunction

endpackage

// File: rtl/pwm_nest_timebase.sv
// Timebase: prescaler, inner counter and outer counter, plus period-start pulses.
// Assumes tick_i is a one-cycle enable at the fastest oscillator rate.
module pwm_nest_timebase
    import pwm_nest_pkg::*;
#(
    parameter int WIDE_W   = 10,
    parameter int NARROW_W = 8,
    parameter int OUTER_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_i,
    input  logic               wide_i,
    input  logic [1:0]         fsel_i,
    output logic [WIDE_W-1:0]  inner_o,
    output logic [OUTER_W-1:0] outer_o,
    output logic               inner_start_o,
    output logic               outer_start_o
);

    localparam logic [WIDE_W-1:0]  WIDE_TOP   = '1;
    localparam logic [WIDE_W-1:0]  NARROW_TOP = WIDE_W'((1 << NARROW_W) - 1);
    localparam logic [OUTER_W-1:0] OUTER_TOP  = '1;

    logic [1:0]         pre_q;
    logic [1:0]         pre_last;
    logic               step;
    logic [WIDE_W-1:0]  inner_top;
    logic               inner_wrap;
    logic               outer_wrap;

    // Decode the step enable and the wrap conditions.
    always_comb begin
        pre_last   = prescale_last(wide_i, fsel_i);
        step       = tick_i && (pre_q >= pre_last);
        inner_top  = wide_i ? WIDE_TOP : NARROW_TOP;
        inner_wrap = (inner_o >= inner_top);
        outer_wrap = (outer_o == OUTER_TOP);
    end

    // Prescaler counting ticks between inner steps.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pre_q <= 2'd0;
        else if (tick_i)
            pre_q <= step ? 2'd0 : pre_q + 2'd1;
    end

    // Inner and outer counters with one-cycle start pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inner_o       <= '0;
            outer_o       <= '0;
            inner_start_o <= 1'b0;
            outer_start_o <= 1'b0;
        end else begin
            inner_start_o <= 1'b0;
            outer_start_o <= 1'b0;
            if (step) begin
                if (inner_wrap) begin
                    inner_o       <= '0;
                    inner_start_o <= 1'b1;
                    if (outer_wrap) begin
                        outer_o       <= '0;
                        outer_start_o <= 1'b1;
                    end else begin
                        outer_o <= outer_o + 1'b1;
                    end
                end else begin
                    inner_o <= inner_o + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/pwm_nest_shadow.sv
// Shadow register: captures a duty vector only on the update strobe.
// Assumes the strobe is a single-cycle pulse; a held strobe reloads every cycle.
module pwm_nest_shadow #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              update_i,
    input  logic [DATA_W-1:0] d_i,
    output logic [DATA_W-1:0] q_o
);

    // Load the whole vector at once so no partial duty is ever seen.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q_o <= '0;
        else if (update_i)
            q_o <= d_i;
    end

endmodule

// File: rtl/pwm_nest_chan.sv
// One channel: compares the counters with its duties and registers the gate.
// Assumes the inner duty is already selected (per channel or per triplet).
module pwm_nest_chan
    import pwm_nest_pkg::*;
#(
    parameter int WIDE_W   = 10,
    parameter int NARROW_W = 8,
    parameter int OUTER_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [WIDE_W-1:0]  inner_i,
    input  logic [OUTER_W-1:0] outer_i,
    input  logic               wide_i,
    input  logic [WIDE_W-1:0]  hfp_i,
    input  logic [OUTER_W-1:0] lfp_i,
    input  logic [GMODE_W-1:0] gmode_i,
    input  logic               shdn_i,
    output logic               on_o
);

    logic [WIDE_W-1:0] hfp_eff;
    logic              inner_hit;
    logic              outer_hit;
    logic              on_next;

    // Pick the compared duty width and evaluate the two layers.
    always_comb begin
        hfp_eff   = wide_i ? hfp_i : {{(WIDE_W-NARROW_W){1'b0}}, hfp_i[NARROW_W-1:0]};
        inner_hit = (inner_i < hfp_eff);
        outer_hit = (outer_i < lfp_i);
        case (gmode_e'(gmode_i))
            GM_NESTED: on_next = inner_hit && outer_hit;
            GM_INNER:  on_next = inner_hit;
            GM_DC:     on_next = 1'b1;
            default:   on_next = 1'b0;
        endcase
    end

    // Registered gate, forced low by shutdown.
    always_ff @(posedge clk) begin
        if (!rst_n)
            on_o <= 1'b0;
        else
            on_o <= shdn_i ? 1'b0 : on_next;
    end

endmodule

// File: rtl/pwm_nest_gen.sv
// Top of the nested PWM generator: timebase, shadow duties and per-channel gates.
// Assumes NUM_CH is a multiple of the colour class count.
module pwm_nest_gen
    import pwm_nest_pkg::*;
#(
    parameter int NUM_CH   = 36,
    parameter int WIDE_W   = 10,
    parameter int NARROW_W = 8,
    parameter int OUTER_W  = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          tick_i,
    input  logic                          wide_i,
    input  logic [1:0]                    fsel_i,
    input  logic [CLASS_CNT*GMODE_W-1:0]  mode_i,
    input  logic                          sw_shdn_i,
    input  logic                          rgb_i,
    input  logic                          update_i,
    input  logic [NUM_CH*WIDE_W-1:0]      hfp_duty_i,
    input  logic [NUM_CH*OUTER_W-1:0]     lfp_duty_i,
    output logic [NUM_CH-1:0]             ch_on_o,
    output logic [WIDE_W-1:0]             inner_cnt_o,
    output logic [OUTER_W-1:0]            outer_cnt_o,
    output logic                          inner_start_o,
    output logic                          outer_start_o
);

    localparam int HFP_BITS = NUM_CH * WIDE_W;
    localparam int LFP_BITS = NUM_CH * OUTER_W;

    logic [HFP_BITS-1:0] hfp_shadow;
    logic [LFP_BITS-1:0] lfp_shadow;

    pwm_nest_timebase #(
        .WIDE_W   (WIDE_W),
        .NARROW_W (NARROW_W),
        .OUTER_W  (OUTER_W)
    ) u_timebase (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick_i        (tick_i),
        .wide_i        (wide_i),
        .fsel_i        (fsel_i),
        .inner_o       (inner_cnt_o),
        .outer_o       (outer_cnt_o),
        .inner_start_o (inner_start_o),
        .outer_start_o (outer_start_o)
    );

    pwm_nest_shadow #(.DATA_W(HFP_BITS)) u_hfp_shadow (
        .clk      (clk),
        .rst_n    (rst_n),
        .update_i (update_i),
        .d_i      (hfp_duty_i),
        .q_o      (hfp_shadow)
    );

    pwm_nest_shadow #(.DATA_W(LFP_BITS)) u_lfp_shadow (
        .clk      (clk),
        .rst_n    (rst_n),
        .update_i (update_i),
        .d_i      (lfp_duty_i),
        .q_o      (lfp_shadow)
    );

    // One gate per channel; the inner duty source depends on RGB mode.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam int GRP = c / CLASS_CNT;
        localparam int CLS = c % CLASS_CNT;
        logic [WIDE_W-1:0] hfp_sel;

        // Select own field or the shared triplet field.
        always_comb begin
            hfp_sel = rgb_i ? hfp_shadow[GRP*WIDE_W +: WIDE_W]
                            : hfp_shadow[c*WIDE_W +: WIDE_W];
        end

        pwm_nest_chan #(
            .WIDE_W   (WIDE_W),
            .NARROW_W (NARROW_W),
            .OUTER_W  (OUTER_W)
        ) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .inner_i (inner_cnt_o),
            .outer_i (outer_cnt_o),
            .wide_i  (wide_i),
            .hfp_i   (hfp_sel),
            .lfp_i   (lfp_shadow[c*OUTER_W +: OUTER_W]),
            .gmode_i (mode_i[CLS*GMODE_W +: GMODE_W]),
            .shdn_i  (sw_shdn_i),
            .on_o    (ch_on_o[c])
        );
    end

endmodule

// File: rtl/pwm_nest_checker.sv
// Property checker bound to the nested PWM generator.
module pwm_nest_checker
    import pwm_nest_pkg::*;
#(
    parameter int NUM_CH  = 36,
    parameter int WIDE_W  = 10,
    parameter int OUTER_W = 8
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         tick_i,
    input logic                         update_i,
    input logic                         sw_shdn_i,
    input logic [CLASS_CNT*GMODE_W-1:0] mode_i,
    input logic [NUM_CH*WIDE_W-1:0]     hfp_duty_i,
    input logic [NUM_CH*WIDE_W-1:0]     hfp_shadow,
    input logic [NUM_CH*OUTER_W-1:0]    lfp_shadow,
    input logic [WIDE_W-1:0]            inner_cnt_o,
    input logic [OUTER_W-1:0]           outer_cnt_o,
    input logic                         inner_start_o,
    input logic                         outer_start_o,
    input logic [NUM_CH-1:0]            ch_on_o
);

    localparam logic [CLASS_CNT*GMODE_W-1:0] ALL_DC  = {CLASS_CNT{2'b10}};
    localparam logic [CLASS_CNT*GMODE_W-1:0] ALL_OFF = {CLASS_CNT{2'b11}};

    assert_tick_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> ($stable(inner_cnt_o) && $stable(outer_cnt_o)));

    assert_outer_moves_on_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(outer_cnt_o) |-> inner_start_o);

    assert_outer_start_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
        outer_start_o |-> (inner_start_o && outer_cnt_o == '0 && inner_cnt_o == '0));

    assert_inner_start_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        inner_start_o |-> (inner_cnt_o == '0));

    assert_shutdown_dark_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sw_shdn_i |=> (ch_on_o == '0));

    assert_dc_all_on_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_shdn_i && mode_i == ALL_DC) |=> (&ch_on_o));

    assert_off_all_dark_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == ALL_OFF) |=> (ch_on_o == '0));

    assert_shadow_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !update_i |=> ($stable(hfp_shadow) && $stable(lfp_shadow)));

    assert_shadow_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        update_i |=> (hfp_shadow == $past(hfp_duty_i)));

    assert_zero_outer_dark_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i[1:0] == 2'b00 && lfp_shadow[OUTER_W-1:0] == '0) |=> !ch_on_o[0]);

endmodule

bind pwm_nest_gen pwm_nest_checker #(
    .NUM_CH  (NUM_CH),
    .WIDE_W  (WIDE_W),
    .OUTER_W (OUTER_W)
) u_pwm_nest_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick_i        (tick_i),
    .update_i      (update_i),
    .sw_shdn_i     (sw_shdn_i),
    .mode_i        (mode_i),
    .hfp_duty_i    (hfp_duty_i),
    .hfp_shadow    (hfp_shadow),
    .lfp_shadow    (lfp_shadow),
    .inner_cnt_o   (inner_cnt_o),
    .outer_cnt_o   (outer_cnt_o),
    .inner_start_o (inner_start_o),
    .outer_start_o (outer_start_o),
    .ch_on_o       (ch_on_o)
);

// File: tb/pwm_nest_gen_test.sv
`timescale 1ns/1ps
module pwm_nest_gen_test;

    localparam int NUM_CH = 36;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 tick_i = 1'b0;
    logic                 wide_i = 1'b0;
    logic [1:0]           fsel_i = 2'b00;
    logic [5:0]           mode_i = 6'd0;
    logic                 sw_shdn_i = 1'b0;
    logic                 rgb_i = 1'b0;
    logic                 update_i = 1'b0;
    logic [NUM_CH*10-1:0] hfp_duty_i = '0;
    logic [NUM_CH*8-1:0]  lfp_duty_i = '0;
    logic [NUM_CH-1:0]    ch_on_o;
    logic [9:0]           inner_cnt_o;
    logic [7:0]           outer_cnt_o;
    logic                 inner_start_o;
    logic                 outer_start_o;

    logic [NUM_CH*10-1:0] sh_hfp = '0;
    logic [NUM_CH*8-1:0]  sh_lfp = '0;
    int                   n_checks = 0;
    int                   n_fail = 0;
    logic                 done = 1'b0;

    always #2 clk = ~clk;

    pwm_nest_gen uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick_i        (tick_i),
        .wide_i        (wide_i),
        .fsel_i        (fsel_i),
        .mode_i        (mode_i),
        .sw_shdn_i     (sw_shdn_i),
        .rgb_i         (rgb_i),
        .update_i      (update_i),
        .hfp_duty_i    (hfp_duty_i),
        .lfp_duty_i    (lfp_duty_i),
        .ch_on_o       (ch_on_o),
        .inner_cnt_o   (inner_cnt_o),
        .outer_cnt_o   (outer_cnt_o),
        .inner_start_o (inner_start_o),
        .outer_start_o (outer_start_o)
    );

    // Expected gate vector from counters, live controls and the bench shadow.
    function automatic logic [NUM_CH-1:0] model(input logic [9:0] inner, input logic [7:0] outer);
        logic [NUM_CH-1:0] v;
        logic [9:0] h;
        logic [9:0] he;
        logic [7:0] l;
        logic [1:0] m;
        logic ion;
        logic oon;
        v = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            h   = rgb_i ? sh_hfp[(c/3)*10 +: 10] : sh_hfp[c*10 +: 10];
            he  = wide_i ? h : {2'b00, h[7:0]};
            l   = sh_lfp[c*8 +: 8];
            m   = mode_i[(c%3)*2 +: 2];
            ion = (inner < he);
            oon = (outer < l);
            case (m)
                2'b00:   v[c] = ion && oon;
                2'b01:   v[c] = ion;
                2'b10:   v[c] = 1'b1;
                default: v[c] = 1'b0;
            endcase
            if (sw_shdn_i) v[c] = 1'b0;
        end
        return v;
    endfunction

    task automatic check_vec(input string tag, input logic [NUM_CH-1:0] got, input logic [NUM_CH-1:0] exp_v);
        n_checks++;
        if (got !== exp_v) begin
            n_fail++;
            $display("FAIL %s: ch_on actual %h expected %h", tag, got, exp_v);
        end
    endtask

    task automatic check_int(input string tag, input int got, input int exp_v);
        n_checks++;
        if (got != exp_v) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, got, exp_v);
        end
    endtask

    // One clock: predict, let the edge happen, compare at the falling edge.
    task automatic cycle(input string tag);
        logic [NUM_CH-1:0] exp_v;
        exp_v = model(inner_cnt_o, outer_cnt_o);
        if (update_i) begin
            sh_hfp = hfp_duty_i;
            sh_lfp = lfp_duty_i;
        end
        @(posedge clk);
        @(negedge clk);
        check_vec(tag, ch_on_o, exp_v);
    endtask

    task automatic load(input string tag);
        update_i = 1'b1;
        cycle(tag);
        update_i = 1'b0;
    endtask

    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) cycle(tag);
    endtask

    task automatic fill(input logic [9:0] h, input logic [7:0] l);
        for (int c = 0; c < NUM_CH; c++) begin
            hfp_duty_i[c*10 +: 10] = h;
            lfp_duty_i[c*8 +: 8]   = l;
        end
    endtask

    // Inner period length for one resolution and rate select.
    task automatic measure(input logic wide, input logic [1:0] fs, input int exp_len);
        int guard;
        int n;
        wide_i = wide;
        fsel_i = fs;
        tick_i = 1'b1;
        guard  = 0;
        while (!inner_start_o && guard < 3000) begin
            cycle("R2");
            guard++;
        end
        n = 0;
        do begin
            cycle("R2");
            n++;
        end while (!inner_start_o && n < 3000);
        check_int("R2 inner period", n, exp_len);
    endtask

    task automatic rand_scn(input int n, input logic small_outer, input logic force_rgb);
        for (int c = 0; c < NUM_CH; c++) begin
            hfp_duty_i[c*10 +: 10] = ($urandom % 8 == 0) ? 10'd0 : 10'($urandom);
            lfp_duty_i[c*8 +: 8]   = small_outer ? 8'($urandom % 16) : 8'($urandom);
        end
        mode_i = 6'($urandom);
        wide_i = 1'($urandom);
        fsel_i = 2'($urandom);
        rgb_i  = force_rgb | 1'($urandom);
        tick_i = 1'b1;
        load("R10");
        for (int i = 0; i < n; i++) begin
            tick_i = ($urandom % 4) != 0;
            cycle("random R5 R6 R7 R8 R11 R12");
        end
    endtask

    // Watchdog ends a hung run as a failure.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [9:0] inn;
        logic [7:0] outr;
        logic [7:0] last_outer;
        int seen;
        void'($urandom(32'd5150));

        // R1: reset state.
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_vec("R1 gates", ch_on_o, '0);
        check_int("R1 inner", int'(inner_cnt_o), 0);
        check_int("R1 outer", int'(outer_cnt_o), 0);
        check_int("R1 starts", int'({inner_start_o, outer_start_o}), 0);
        rst_n = 1'b1;

        // R2: inner period for every resolution and rate select.
        measure(1'b1, 2'b01, 1024);
        measure(1'b0, 2'b00, 1024);
        measure(1'b0, 2'b01, 512);
        measure(1'b0, 2'b10, 256);
        measure(1'b0, 2'b11, 256);

        // R4: counters hold with no tick.
        tick_i = 1'b0;
        inn  = inner_cnt_o;
        outr = outer_cnt_o;
        run(40, "R4 gates");
        check_int("R4 inner hold", int'(inner_cnt_o), int'(inn));
        check_int("R4 outer hold", int'(outer_cnt_o), int'(outr));

        // R5: zero inner duty with full outer duty stays dark.
        tick_i = 1'b1; wide_i = 1'b1; mode_i = 6'b00_00_00; rgb_i = 1'b0;
        fill(10'd0, 8'd255);
        load("R5");
        run(1100, "R5 zero duty");
        check_vec("R5 dark", ch_on_o, '0);

        // R6: inner-only mode ignores a zero outer duty.
        mode_i = 6'b01_01_01;
        fill(10'd512, 8'd0);
        load("R6");
        run(1100, "R6 inner only");

        // R7: mixed class modes; class 0 DC, class 1 off, class 2 nested.
        mode_i = 6'b00_11_10;
        fill(10'd300, 8'd255);
        load("R7");
        run(1100, "R7 class modes");

        // R8: upper inner-duty bits ignored in 8-bit mode.
        wide_i = 1'b0; fsel_i = 2'b10; mode_i = 6'b01_01_01;
        fill(10'h300, 8'd255);
        load("R8");
        run(300, "R8 high bits only");
        check_vec("R8 dark", ch_on_o, '0);
        fill(10'h3FF, 8'd255);
        load("R8");
        run(300, "R8 low byte");

        // R9: shutdown forces dark, duties survive it.
        mode_i = 6'b10_10_10;
        sw_shdn_i = 1'b1;
        run(50, "R9 shutdown");
        check_vec("R9 dark", ch_on_o, '0);
        sw_shdn_i = 1'b0;
        mode_i = 6'b01_01_01;
        run(300, "R9 resume");

        // R10: inputs change without strobe: no effect.
        wide_i = 1'b1; mode_i = 6'b00_00_00;
        fill(10'd0, 8'd0);
        load("R10");
        fill(10'h3FF, 8'd255);
        run(1100, "R10 no strobe");
        check_vec("R10 still dark", ch_on_o, '0);
        load("R10");
        run(1100, "R10 after strobe");

        // R11: triplets share inner duty, keep own outer duty.
        rgb_i = 1'b1; mode_i = 6'b00_00_00;
        for (int c = 0; c < NUM_CH; c++) begin
            hfp_duty_i[c*10 +: 10] = 10'(c * 28 + 5);
            lfp_duty_i[c*8 +: 8]   = (c % 3 == 1) ? 8'd0 : 8'd255;
        end
        load("R11");
        run(1100, "R11 rgb map");
        rgb_i = 1'b0;

        // R12: mode flip seen exactly one edge later.
        mode_i = 6'b11_11_11;
        cycle("R12 off");
        mode_i = 6'b10_10_10;
        cycle("R12 on next edge");
        check_vec("R12 all on", ch_on_o, '1);

        // R3: outer sweep over a whole outer period.
        wide_i = 1'b0; fsel_i = 2'b11; tick_i = 1'b1; mode_i = 6'b00_00_00;
        for (int c = 0; c < NUM_CH; c++) begin
            hfp_duty_i[c*10 +: 10] = 10'($urandom % 256);
            lfp_duty_i[c*8 +: 8]   = 8'($urandom);
        end
        load("R3");
        seen = 0;
        last_outer = outer_cnt_o;
        for (int i = 0; i < 66000; i++) begin
            cycle("R3 R5 sweep");
            if (inner_start_o) begin
                check_int("R3 outer step", int'(outer_cnt_o), int'(8'(last_outer + 8'd1)));
                last_outer = outer_cnt_o;
            end
            if (outer_start_o) begin
                seen++;
                check_int("R3 outer start at zero", int'({inner_cnt_o, outer_cnt_o}), 0);
            end
        end
        check_int("R3 outer period seen", (seen >= 1) ? 1 : 0, 1);

        // Random mixes.
        rand_scn(2500, 1'b0, 1'b0);
        rand_scn(2500, 1'b1, 1'b0);
        rand_scn(2500, 1'b1, 1'b1);
        rand_scn(2500, 1'b0, 1'b1);
        rand_scn(2500, 1'b1, 1'b0);
        rand_scn(2500, 1'b1, 1'b1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule